// File: doc/BRIEF.md
# Audio Serial Output Port

This block is the serial output stage of a stereo audio converter. It takes a left and a right 24-bit two's-complement sample and sends them on a single data line, most significant bit first. The data line changes only on the falling edge of a bit clock. The block runs from one system clock `clk`. The external master clock, bit clock and frame sync arrive as plain inputs, and the block samples them in the `clk` domain.

In master mode the block makes its own bit clock and frame sync from the master clock. A two-bit speed code picks the ratios. The code also sets the frame length: 64 bit-clock periods per channel at normal speed, and 32 at double and quad speed. The frame sync is high for the left half-frame and low for the right half-frame. Each sample is followed by zero bits until its half-frame ends. Both samples are captured together when a frame starts. A new speed code takes effect only at the next frame start.

In slave mode the bit clock and frame sync come from outside. Data is shifted out only while the frame sync is high: 24 left bits, then 24 right bits, then zeros. In slave mode the block drives its own clock outputs low.

Top module: `audioSerialPort`

## Requirements
- R1: Speed code 00 is normal speed, 01 is double speed and 10 is quad speed. In master mode, `bclkOut` toggles on every rising edge of `mclkIn` for codes 00 and 01, so its period is two master-clock periods. For code 10 it toggles on every edge of `mclkIn`, so its period is one master-clock period.
- R2: `speedBad` is high exactly while `speedSel` is 11. Code 11 never becomes the active speed: at a frame start the previous speed is kept, and during reset 11 is treated as 00.
- R3: In master mode the frame sync is high for 64 bit-clock periods and then low for 64 at normal speed. At double and quad speed it is high for 32 and then low for 32. The frame sync changes only together with a falling edge of `bclkOut`.
- R4: `sdata` changes only in the same `clk` cycle as a falling edge of the bit clock. Each half-frame carries its 24-bit sample MSB first, and every later bit of that half-frame is 0.
- R5: The half-frame with frame sync high carries the left sample and the half-frame with frame sync low carries the right sample. Both samples are captured at the falling edge that starts the frame. Input changes during the frame appear only in the next frame.
- R6: While `rstN` is low, `fsyncOut` and `sdata` are low. `bclkOut` is low, except in master mode with code 10, where it equals the inverted `mclkIn`.
- R7: After `rstN` is released in master mode, the first falling edge of `bclkOut` starts a left half-frame. At most one rising edge of `bclkOut` comes before it.
- R8: A change of `speedSel` made in the middle of a frame leaves that frame's length unchanged. The next frame uses the new speed.
- R9: In slave mode, `bclkOut` and `fsyncOut` stay low. While `fsyncIn` is low, `sdata` is 0. The first falling edge of `bclkIn` with `fsyncIn` high presents the left MSB. Each later falling edge presents the next bit: 24 left bits, then 24 right bits, then zeros.
- R10: In slave mode, both samples are captured at the first falling edge of a frame-sync-high period. Later input changes do not affect that period's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all serial-side inputs |
| rstN | input | 1 | Active-low synchronous reset |
| masterMode | input | 1 | 1: generate the clocks; 0: follow the external clocks |
| speedSel | input | 2 | Speed code (00 normal, 01 double, 10 quad, 11 invalid) |
| mclkIn | input | 1 | Master clock, sampled in the `clk` domain |
| bclkIn | input | 1 | External bit clock, used in slave mode |
| fsyncIn | input | 1 | External frame sync, used in slave mode |
| leftSample | input | 24 | Left-channel sample, two's complement |
| rightSample | input | 24 | Right-channel sample, two's complement |
| bclkOut | output | 1 | Generated bit clock |
| fsyncOut | output | 1 | Generated frame sync (high marks the left half-frame) |
| sdata | output | 1 | Serial data line |
| speedBad | output | 1 | Flags the unsupported speed code |

## Verification
The hardest case to reach is a speed change that falls inside a frame. The old ratio must hold until the frame ends, and the new ratio must start exactly at the next frame start, even across a change between quad speed and a divide-by-two speed. The bench changes `speedSel` when it sees the first bit of the first right half-frame. It then decodes every later half-frame, like a receiver, and checks its length and bit-clock period. Driving the invalid code in the same way, and holding it through reset, shows that the active speed never takes that value.

// File: rtl/audioSerPkg.sv
package audioSerPkg;

  typedef enum logic [1:0] {
    SPD_NORMAL = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_BAD    = 2'b11
  } speedT;

  // strobes from the control to the shift datapath
  typedef struct packed {
    logic loadLeft;   // capture both samples, present left MSB
    logic loadRight;  // present right MSB from the held copy
    logic shiftOn;    // present the next bit
    logic clearOut;   // force the line and the shifter to zero
  } strobeT;

endpackage

// File: rtl/syncChain.sv
module syncChain #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) stage[0] <= dIn;

  for (genvar s = 1; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk) stage[s] <= stage[s-1];
  end

  assign dOut = stage[STAGES-1];

endmodule

// File: rtl/serCtrl.sv
module serCtrl
  import audioSerPkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int HALF_SLOW = 64,
  parameter int HALF_FAST = 32,
  parameter int SYNC_N    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       masterMode,
  input  logic [1:0] speedSel,
  input  logic       mclkIn,
  input  logic       bclkIn,
  input  logic       fsyncIn,
  output logic       bclkOut,
  output logic       fsyncOut,
  output logic       speedBad,
  output strobeT     strobe
);

  localparam int CNT_W = $clog2(2 * HALF_SLOW);
  localparam int SLV_W = $clog2(2 * SAMPLE_W) + 1;
  localparam logic [CNT_W-1:0] SLOW_MID  = CNT_W'(HALF_SLOW - 1);
  localparam logic [CNT_W-1:0] FAST_MID  = CNT_W'(HALF_FAST - 1);
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(2 * HALF_SLOW - 1);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(2 * HALF_FAST - 1);
  localparam logic [SLV_W-1:0] SLV_SWAP  = SLV_W'(SAMPLE_W - 1);

  // sampled versions of the external clock-like inputs
  logic [2:0] syncd;
  logic mclkS, bclkS, fsyncS;
  logic mclkD, bclkInD;

  syncChain #(.WIDTH(3), .STAGES(SYNC_N)) u_sync (
    .clk  (clk),
    .dIn  ({fsyncIn, bclkIn, mclkIn}),
    .dOut (syncd)
  );
  assign mclkS  = syncd[0];
  assign bclkS  = syncd[1];
  assign fsyncS = syncd[2];

  speedT activeSpeed, nextSpeed;
  logic bclkReg, fsyncReg, started;
  logic [CNT_W-1:0] frameCnt;
  logic slvRun;
  logic [SLV_W-1:0] slvIdx;

  logic speedValid, mclkRise, mclkFall, tick, bitFall;
  logic [CNT_W-1:0] midCnt, lastCnt;
  logic frameEnd, startFrame, enterRight, masterShift;
  logic extFall, slvLoad, slvRight, slvShift;

  always_comb begin
    speedValid = (speedSel != SPD_BAD);
    nextSpeed  = speedValid ? speedT'(speedSel) : activeSpeed;
    mclkRise   = mclkS & ~mclkD;
    mclkFall   = ~mclkS & mclkD;
    tick       = (activeSpeed == SPD_QUAD) ? (mclkRise | mclkFall) : mclkRise;
    bitFall    = masterMode & rstN & tick & bclkReg;
    midCnt     = (activeSpeed == SPD_NORMAL) ? SLOW_MID  : FAST_MID;
    lastCnt    = (activeSpeed == SPD_NORMAL) ? SLOW_LAST : FAST_LAST;
    frameEnd   = (frameCnt == lastCnt);
    startFrame  = bitFall & (~started | frameEnd);
    enterRight  = bitFall & started & ~frameEnd & (frameCnt == midCnt);
    masterShift = bitFall & started & ~frameEnd & ~enterRight;

    extFall  = ~masterMode & rstN & bclkInD & ~bclkS;
    slvLoad  = extFall & fsyncS & ~slvRun;
    slvRight = extFall & fsyncS & slvRun & (slvIdx == SLV_SWAP);
    slvShift = extFall & fsyncS & slvRun & (slvIdx != SLV_SWAP);

    strobe.loadLeft  = startFrame | slvLoad;
    strobe.loadRight = enterRight | slvRight;
    strobe.shiftOn   = masterShift | slvShift;
    strobe.clearOut  = ~rstN | (~masterMode & ~fsyncS);
  end

  always_ff @(posedge clk) begin
    mclkD   <= mclkS;
    bclkInD <= bclkS;
  end

  // master-mode clock and frame generation
  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeSpeed <= speedValid ? speedT'(speedSel) : SPD_NORMAL;
      bclkReg     <= (masterMode && speedSel == SPD_QUAD) ? ~mclkS : 1'b0;
      fsyncReg    <= 1'b0;
      started     <= 1'b0;
      frameCnt    <= '0;
    end else if (!masterMode) begin
      bclkReg  <= 1'b0;
      fsyncReg <= 1'b0;
      started  <= 1'b0;
      frameCnt <= '0;
    end else begin
      if (tick) bclkReg <= ~bclkReg;
      if (startFrame) begin
        activeSpeed <= nextSpeed;
        frameCnt    <= '0;
        fsyncReg    <= 1'b1;
        started     <= 1'b1;
      end else if (enterRight) begin
        frameCnt <= frameCnt + 1'b1;
        fsyncReg <= 1'b0;
      end else if (masterShift) begin
        frameCnt <= frameCnt + 1'b1;
      end
    end
  end

  // slave-mode bit position tracking
  always_ff @(posedge clk) begin
    if (!rstN || masterMode || !fsyncS) begin
      slvRun <= 1'b0;
      slvIdx <= '0;
    end else if (slvLoad) begin
      slvRun <= 1'b1;
      slvIdx <= '0;
    end else if ((slvRight || slvShift) && slvIdx != '1) begin
      slvIdx <= slvIdx + 1'b1;
    end
  end

  assign bclkOut  = bclkReg;
  assign fsyncOut = fsyncReg;
  assign speedBad = ~speedValid;

endmodule

// File: rtl/serData.sv
module serData
  import audioSerPkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  strobeT              strobe,
  input  logic [SAMPLE_W-1:0] leftSample,
  input  logic [SAMPLE_W-1:0] rightSample,
  output logic                sdata
);

  localparam int MSB = SAMPLE_W - 1;

  logic [SAMPLE_W-1:0] rightHold;
  logic [SAMPLE_W-1:0] shifter;
  logic                lineReg;

  always_ff @(posedge clk) begin
    if (strobe.clearOut) begin
      lineReg <= 1'b0;
      shifter <= '0;
    end else if (strobe.loadLeft) begin
      rightHold <= rightSample;
      lineReg   <= leftSample[MSB];
      shifter   <= {leftSample[MSB-1:0], 1'b0};
    end else if (strobe.loadRight) begin
      lineReg <= rightHold[MSB];
      shifter <= {rightHold[MSB-1:0], 1'b0};
    end else if (strobe.shiftOn) begin
      // zeros enter from the bottom, padding the rest of the half-frame
      lineReg <= shifter[MSB];
      shifter <= {shifter[MSB-1:0], 1'b0};
    end
  end

  assign sdata = lineReg;

endmodule

// File: rtl/audioSerialPort.sv
module audioSerialPort
  import audioSerPkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int HALF_SLOW = 64,
  parameter int HALF_FAST = 32,
  parameter int SYNC_N    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                masterMode,
  input  logic [1:0]          speedSel,
  input  logic                mclkIn,
  input  logic                bclkIn,
  input  logic                fsyncIn,
  input  logic [SAMPLE_W-1:0] leftSample,
  input  logic [SAMPLE_W-1:0] rightSample,
  output logic                bclkOut,
  output logic                fsyncOut,
  output logic                sdata,
  output logic                speedBad
);

  strobeT strobe;

  serCtrl #(
    .SAMPLE_W  (SAMPLE_W),
    .HALF_SLOW (HALF_SLOW),
    .HALF_FAST (HALF_FAST),
    .SYNC_N    (SYNC_N)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .masterMode (masterMode),
    .speedSel   (speedSel),
    .mclkIn     (mclkIn),
    .bclkIn     (bclkIn),
    .fsyncIn    (fsyncIn),
    .bclkOut    (bclkOut),
    .fsyncOut   (fsyncOut),
    .speedBad   (speedBad),
    .strobe     (strobe)
  );

  serData #(.SAMPLE_W(SAMPLE_W)) u_data (
    .clk         (clk),
    .strobe      (strobe),
    .leftSample  (leftSample),
    .rightSample (rightSample),
    .sdata       (sdata)
  );

endmodule

// File: rtl/audioSerialPort_chk.sv
module audioSerialPort_chk (
  input logic       clk,
  input logic       rstN,
  input logic       masterMode,
  input logic [1:0] speedSel,
  input logic       fsyncIn,
  input logic       bclkOut,
  input logic       fsyncOut,
  input logic       sdata
);

  // R6: reset forces frame sync and data low
  a_r6_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!fsyncOut && !sdata));

  // R6: reset keeps the bit clock low unless master quad speed
  a_r6_reset_bclk_low: assert property (@(posedge clk)
    (!rstN && !(masterMode && speedSel == 2'b10)) |=> !bclkOut);

  // R4: in master mode the data line moves only with a bit-clock fall
  a_r4_data_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && $past(rstN) && !$stable(sdata)) |-> $fell(bclkOut));

  // R3: frame sync moves only with a bit-clock fall
  a_r3_fsync_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && $past(rstN) && !$stable(fsyncOut)) |-> $fell(bclkOut));

  // R9: slave mode keeps the generated clocks low
  a_r9_slave_clocks_low: assert property (@(posedge clk)
    !masterMode |=> (masterMode || (!bclkOut && !fsyncOut)));

  // R9: slave data line is zero once a low frame sync has propagated
  a_r9_slave_gated: assert property (@(posedge clk) disable iff (!rstN)
    (!masterMode && $past(!masterMode) && $past(!fsyncIn, 3)) |-> !sdata);

endmodule

bind audioSerialPort audioSerialPort_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .masterMode (masterMode),
  .speedSel   (speedSel),
  .fsyncIn    (fsyncIn),
  .bclkOut    (bclkOut),
  .fsyncOut   (fsyncOut),
  .sdata      (sdata)
);

// File: tb/audioSerialPort_bench.sv
`timescale 1ns/1ps
module audioSerialPort_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        masterMode = 1'b1;
  logic [1:0]  speedSel = 2'b00;
  logic        mclkIn = 1'b0;
  logic        bclkIn = 1'b1;
  logic        fsyncIn = 1'b0;
  logic [23:0] leftSample = '0;
  logic [23:0] rightSample = '0;
  logic        bclkOut, fsyncOut, sdata, speedBad;

  int nChecks = 0;
  int nFails = 0;
  int mph = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  // master clock: four clk cycles per phase
  always @(negedge clk) begin
    if (mph == 3) begin
      mclkIn <= ~mclkIn;
      mph    <= 0;
    end else begin
      mph <= mph + 1;
    end
  end

  audioSerialPort u_audioSerialPort (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .speedSel(speedSel),
    .mclkIn(mclkIn), .bclkIn(bclkIn), .fsyncIn(fsyncIn),
    .leftSample(leftSample), .rightSample(rightSample),
    .bclkOut(bclkOut), .fsyncOut(fsyncOut), .sdata(sdata), .speedBad(speedBad)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [23:0] patL(input int seed, input int fr);
    logic [31:0] v;
    v = (fr + 1) * 32'h00A5C3F7 + seed * 32'h01234567;
    return v[27:4];
  endfunction

  function automatic logic [23:0] patR(input int seed, input int fr);
    return patL(seed + 7, fr) ^ 24'h5A5A5A;
  endfunction

  function automatic int effSpd(input logic [1:0] s0, input logic [1:0] s1, input int fr);
    int a;
    a = (s0 == 2'b11) ? 0 : int'(s0);
    if (fr > 0 && s1 != 2'b11) a = int'(s1);
    return a;
  endfunction

  task automatic runMaster(input logic [1:0] sel0, input logic [1:0] sel1, input int nFrames);
    int seed, bad, pre, frame, half, cnt, zeroErr, cyc, lastRise;
    int perErr, perAct, perExp, alignErr, spd;
    logic [23:0] acc, expV;
    logic prevB, prevS, prevF;
    seed = int'(sel0) * 4 + int'(sel1);
    masterMode = 1'b1;
    speedSel = sel0;
    leftSample = patL(seed, 0);
    rightSample = patR(seed, 0);
    rstN = 1'b0;
    repeat (6) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk); #1;
      if (mph == 3 && bclkOut !== ((sel0 == 2'b10) ? ~mclkIn : 1'b0)) bad++;
      if (fsyncOut !== 1'b0 || sdata !== 1'b0) bad++;
    end
    check(bad == 0, "R6", "bit clock, frame sync, data during reset", bad, 0);
    check(speedBad === (sel0 == 2'b11), "R2", "flag during reset", speedBad, sel0 == 2'b11);
    @(negedge clk);
    rstN = 1'b1;
    prevB = bclkOut; prevS = sdata; prevF = fsyncOut;
    pre = 0; frame = -1; half = -1; cnt = 0; zeroErr = 0; cyc = 0; lastRise = 0;
    perErr = 0; perAct = 0; perExp = 0; alignErr = 0; acc = '0;
    while (frame < nFrames) begin
      @(negedge clk); #1;
      cyc++;
      if (sdata !== prevS && !(prevB && !bclkOut)) alignErr++;
      if (fsyncOut !== prevF && !(prevB && !bclkOut)) alignErr++;
      if (bclkOut && !prevB) begin
        if (frame < 0 && !fsyncOut) begin
          pre++;
        end else begin
          if (half < 0 || fsyncOut != (half == 0)) begin
            if (half >= 0) begin
              spd = effSpd(sel0, sel1, frame);
              check(cnt == ((spd == 0) ? 64 : 32), "R3 R8", "half-frame length", cnt,
                    (spd == 0) ? 64 : 32);
              expV = (half == 0) ? patL(seed, frame) : patR(seed, frame);
              check(acc == expV, "R5", (half == 0) ? "left word" : "right word (latched)",
                    acc, expV);
              check(zeroErr == 0, "R4", "padding bits zero", zeroErr, 0);
            end
            half = fsyncOut ? 0 : 1;
            if (half == 0) begin
              frame++;
            end else begin
              leftSample = patL(seed, frame + 1);
              rightSample = patR(seed, frame + 1);
              if (frame == 0) speedSel = sel1;
            end
            cnt = 0; acc = '0; zeroErr = 0;
          end else begin
            spd = effSpd(sel0, sel1, frame);
            if (cyc - lastRise != ((spd == 2) ? 8 : 16)) begin
              perErr++; perAct = cyc - lastRise; perExp = (spd == 2) ? 8 : 16;
            end
          end
          if (cnt < 24) acc = {acc[22:0], sdata};
          else if (sdata !== 1'b0) zeroErr++;
          cnt++;
          lastRise = cyc;
        end
      end
      prevB = bclkOut; prevS = sdata; prevF = fsyncOut;
    end
    check(pre <= 1, "R7", "rising edges before first left half-frame", pre, 1);
    check(perErr == 0, "R1", "bit clock period in clk cycles", perAct, perExp);
    check(alignErr == 0, "R4", "changes away from bit-clock fall", alignErr, 0);
    check(speedBad === (sel1 == 2'b11), "R2", "flag after code change", speedBad, sel1 == 2'b11);
  endtask

  task automatic slaveBit(output logic got);
    bclkIn = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    got = sdata;
  endtask

  task automatic runSlave(input int highBits, input int seed);
    logic [23:0] expL, expR, accL, accR;
    logic got;
    int idleErr, extraErr, quietErr;
    masterMode = 1'b0;
    fsyncIn = 1'b0;
    bclkIn = 1'b1;
    rstN = 1'b0;
    repeat (8) @(negedge clk);
    rstN = 1'b1;
    expL = patL(seed, 0); expR = patR(seed, 0);
    leftSample = expL; rightSample = expR;
    idleErr = 0; extraErr = 0; quietErr = 0; accL = '0; accR = '0;
    for (int i = 0; i < 4; i++) begin
      slaveBit(got);
      if (got !== 1'b0) idleErr++;
      if (bclkOut !== 1'b0 || fsyncOut !== 1'b0) quietErr++;
      bclkIn = 1'b1;
      repeat (5) @(negedge clk);
    end
    fsyncIn = 1'b1;
    for (int i = 0; i < highBits; i++) begin
      slaveBit(got);
      if (i == 6) begin
        leftSample = ~expL;
        rightSample = ~expR;
      end
      if (i < 24) accL = {accL[22:0], got};
      else if (i < 48) accR = {accR[22:0], got};
      else if (got !== 1'b0) extraErr++;
      if (bclkOut !== 1'b0 || fsyncOut !== 1'b0) quietErr++;
      bclkIn = 1'b1;
      if (i == highBits - 1) fsyncIn = 1'b0;
      repeat (5) @(negedge clk);
    end
    for (int i = 0; i < 3; i++) begin
      slaveBit(got);
      if (got !== 1'b0) idleErr++;
      bclkIn = 1'b1;
      repeat (5) @(negedge clk);
    end
    check(idleErr == 0, "R9", "data while frame sync low", idleErr, 0);
    check(accL == expL, "R10", "slave left word", accL, expL);
    check(accR == expR, "R9", "slave right word", accR, expR);
    check(extraErr == 0, "R9", "slave bits after 48", extraErr, 0);
    check(quietErr == 0, "R9", "generated clocks in slave mode", quietErr, 0);
  endtask

  initial begin
    runMaster(2'b00, 2'b00, 3);
    runMaster(2'b01, 2'b01, 3);
    runMaster(2'b10, 2'b10, 3);
    runMaster(2'b00, 2'b10, 3);
    runMaster(2'b10, 2'b01, 3);
    runMaster(2'b01, 2'b00, 3);
    runMaster(2'b00, 2'b11, 3);
    runMaster(2'b11, 2'b01, 3);
    runSlave(50, 21);
    runSlave(48, 22);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL R1 watchdog: actual timeout expected completion %0d %0d", 1, 0);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule